// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable 15-bit ratio N and returns one feedback pulse per N input cycles to a phase comparator. It does not use one wide binary counter. It is built as a pulse-swallow divider with three parts. A dual-modulus prescaler divides by 8 or by 9. A 3-bit swallow counter holds the remainder A. A 12-bit main counter holds the quotient M. Together they give N = 8·M + A. Because N can take any integer value in its range, the output frequency moves in steps equal to the comparison frequency.

A new ratio is presented on the ratio bus and qualified by a load strobe. The block checks it, holds it as pending, and switches to it only where one output period ends. A retune therefore never produces a short or stretched period. Ratios the block cannot realise are discarded. The block also drives two other outputs. One is the prescaler modulus control. The other is a half-rate copy of the feedback pulse, which toggles once per period and can be routed to a test pin.

Top module: `swallow_divider`

## Requirements
- R1: While reset is asserted, `fb_pulse` and `fpd_half` are 0 and the active ratio is the parameter `DEFAULT_RATIO`, which is 100 by default. The first `fb_pulse` is seen after the 100th rising clock edge following reset release.
- R2: `fb_pulse` is high for exactly one input clock cycle once every N input cycles. N is the active ratio read as an unsigned number, that is 8·`ratio_in[14:3]` + `ratio_in[2:0]`.
- R3: `mod_sel` is 1 (divide by 9) for the first 9·A input cycles of every output period and 0 (divide by 8) for the remaining 8·(M−A) cycles. A is bits 2..0 of the active ratio and M is bits 14..3.
- R4: A valid ratio strobed with `ratio_load` takes effect at the first period boundary at or after the strobe edge. A strobe on the last input cycle of a period governs the very next period. If several valid strobes arrive within one period, the last one wins.
- R5: A strobed ratio below 64, or one whose M is less than its A, is ignored. Neither the active ratio nor any pending valid ratio changes.
- R6: `fpd_half` toggles on exactly those edges where `fb_pulse` rises, so its period is 2·N cycles.
- R7: The largest ratio, 32767 (M = 4095, A = 7), is divided correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_in | input | 15 | Requested division ratio: bits 14..3 = M, bits 2..0 = A |
| ratio_load | input | 1 | Strobe; samples `ratio_in` on this rising edge |
| fb_pulse | output | 1 | One-cycle feedback pulse per N input cycles |
| fpd_half | output | 1 | Half-rate feedback clock for test routing |
| mod_sel | output | 1 | Prescaler modulus: 1 = divide by 9, 0 = divide by 8 |

## Verification
The feedback pulse and the half-rate output both change at the edge that completes the Nth input cycle of a period. The bench therefore samples them at the falling edge after that Nth edge, where its own cycle counter reaches the period length. The modulus control is a decode of the registered swallow state. It is compared at every falling edge against "cycles elapsed in this period < 9·A". A strobe counts at the rising edge where it is sampled. If that edge is also a boundary, the new ratio sets the length of the period that starts there, and the bench model follows the same rule.

// File: rtl/swd_pkg.sv
package swd_pkg;

    // Prescaler modulus selection
    typedef enum logic [0:0] {
        PSC_BASE      = 1'b0,   // divide by 2**A_W
        PSC_BASE_PLUS = 1'b1    // divide by 2**A_W + 1
    } psc_mode_e;

    localparam int SWD_MIN_RATIO_DEF = 64;

endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler
    import swd_pkg::*;
#(
    parameter int A_W = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  psc_mode_e mode,
    output logic      term
);
    localparam int BASE = 1 << A_W;
    localparam int CW   = $clog2(BASE + 1);
    localparam logic [CW-1:0] LAST_BASE = CW'(BASE - 1);
    localparam logic [CW-1:0] LAST_PLUS = CW'(BASE);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;
    logic [CW-1:0] last;

    always_comb begin
        st_d = st_q;
        last = (mode == PSC_BASE_PLUS) ? LAST_PLUS : LAST_BASE;
        term = (st_q.cnt == last);
        if (term) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/swd_swallow.sv
module swd_swallow
    import swd_pkg::*;
#(
    parameter int          A_W    = 3,
    parameter logic [A_W-1:0] INIT_A = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           psc_term,
    input  logic           boundary,
    input  logic [A_W-1:0] reload_a,
    output psc_mode_e      mode
);
    typedef struct packed {
        logic [A_W-1:0] left;
    } swl_st_t;

    swl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        mode = (st_q.left != '0) ? PSC_BASE_PLUS : PSC_BASE;
        if (boundary) begin
            st_d.left = reload_a;
        end else if (psc_term && (st_q.left != '0)) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.left <= INIT_A;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/swd_main_counter.sv
module swd_main_counter #(
    parameter int             M_W    = 12,
    parameter logic [M_W-1:0] INIT_M = M_W'(12)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           psc_term,
    input  logic [M_W-1:0] reload_m,
    output logic           boundary
);
    localparam logic [M_W-1:0] ONE = M_W'(1);

    typedef struct packed {
        logic [M_W-1:0] left;
    } mc_st_t;

    mc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        boundary = psc_term && (st_q.left == ONE);
        if (boundary) begin
            st_d.left = reload_m;
        end else if (psc_term) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.left <= INIT_M;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/swd_ratio_reg.sv
module swd_ratio_reg #(
    parameter int M_W           = 12,
    parameter int A_W           = 3,
    parameter int MIN_RATIO     = 64,
    parameter int DEFAULT_RATIO = 100,
    localparam int RATIO_W      = M_W + A_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               boundary,
    output logic [RATIO_W-1:0] next_ratio,
    output logic [RATIO_W-1:0] act_ratio,
    output logic [RATIO_W-1:0] pend_ratio
);
    typedef struct packed {
        logic [RATIO_W-1:0] act;
        logic [RATIO_W-1:0] pend;
        logic               pend_vld;
    } rr_st_t;

    rr_st_t st_d, st_q;
    logic   req_ok;
    logic   take_now;

    always_comb begin
        st_d = st_q;
        // A realisable ratio needs enough main cycles to hold every swallow cycle
        req_ok = (ratio_in >= RATIO_W'(MIN_RATIO)) &&
                 (ratio_in[RATIO_W-1:A_W] >= M_W'(ratio_in[A_W-1:0]));
        take_now = load && req_ok;

        if (take_now) begin
            next_ratio = ratio_in;
        end else if (st_q.pend_vld) begin
            next_ratio = st_q.pend;
        end else begin
            next_ratio = st_q.act;
        end

        if (boundary) begin
            st_d.act      = next_ratio;
            st_d.pend_vld = 1'b0;
        end else if (take_now) begin
            st_d.pend     = ratio_in;
            st_d.pend_vld = 1'b1;
        end
    end

    assign act_ratio  = st_q.act;
    assign pend_ratio = st_q.pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act      <= RATIO_W'(DEFAULT_RATIO);
            st_q.pend     <= RATIO_W'(DEFAULT_RATIO);
            st_q.pend_vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swd_pkg::*;
#(
    parameter int M_W           = 12,
    parameter int A_W           = 3,
    parameter int MIN_RATIO     = SWD_MIN_RATIO_DEF,
    parameter int DEFAULT_RATIO = 100,
    localparam int RATIO_W      = M_W + A_W
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               ratio_load,
    output logic               fb_pulse,
    output logic               fpd_half,
    output logic               mod_sel
);
    localparam logic [RATIO_W-1:0] DEF_R  = RATIO_W'(DEFAULT_RATIO);
    localparam logic [M_W-1:0]     INIT_M = DEF_R[RATIO_W-1:A_W];
    localparam logic [A_W-1:0]     INIT_A = DEF_R[A_W-1:0];

    typedef struct packed {
        logic pulse;
        logic half;
    } out_st_t;

    out_st_t            st_d, st_q;
    psc_mode_e          psc_mode;
    logic               psc_term;
    logic               boundary;
    logic [RATIO_W-1:0] next_ratio;
    logic [RATIO_W-1:0] act_ratio;
    logic [RATIO_W-1:0] pend_ratio;

    swd_prescaler #(.A_W(A_W)) u_psc (
        .clk   (clk_in),
        .rst_n (rst_n),
        .mode  (psc_mode),
        .term  (psc_term)
    );

    swd_swallow #(.A_W(A_W), .INIT_A(INIT_A)) u_swl (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .psc_term (psc_term),
        .boundary (boundary),
        .reload_a (next_ratio[A_W-1:0]),
        .mode     (psc_mode)
    );

    swd_main_counter #(.M_W(M_W), .INIT_M(INIT_M)) u_main (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .psc_term (psc_term),
        .reload_m (next_ratio[RATIO_W-1:A_W]),
        .boundary (boundary)
    );

    swd_ratio_reg #(
        .M_W           (M_W),
        .A_W           (A_W),
        .MIN_RATIO     (MIN_RATIO),
        .DEFAULT_RATIO (DEFAULT_RATIO)
    ) u_ratio (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .load       (ratio_load),
        .ratio_in   (ratio_in),
        .boundary   (boundary),
        .next_ratio (next_ratio),
        .act_ratio  (act_ratio),
        .pend_ratio (pend_ratio)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = boundary;
        st_d.half  = st_q.half ^ boundary;
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_pulse = st_q.pulse;
    assign fpd_half = st_q.half;
    assign mod_sel  = (psc_mode == PSC_BASE_PLUS);
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
    parameter int M_W       = 12,
    parameter int A_W       = 3,
    parameter int MIN_RATIO = 64,
    localparam int RATIO_W  = M_W + A_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fb_pulse,
    input logic               fpd_half,
    input logic               mod_sel,
    input logic               ratio_load,
    input logic [RATIO_W-1:0] ratio_in,
    input logic [RATIO_W-1:0] act_ratio,
    input logic [RATIO_W-1:0] pend_ratio
);
    logic bad_req;
    assign bad_req = (int'(ratio_in) < MIN_RATIO) ||
                     (int'(ratio_in[RATIO_W-1:A_W]) < int'(ratio_in[A_W-1:0]));

    // R2: pulse lasts a single input cycle
    assert_single_cycle_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    // R6: half-rate output flips with each pulse and never otherwise
    assert_half_flips_on_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_pulse) |-> (fpd_half != $past(fpd_half)));

    assert_half_still_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_pulse |-> $stable(fpd_half));

    // R3: divide-by-9 phase can only begin at the start of a period
    assert_mod_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_sel) |-> fb_pulse);

    // R4: active ratio switches only at a period boundary
    assert_active_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_ratio) |-> fb_pulse);

    // R5: a rejected request leaves the pending ratio untouched
    assert_invalid_keeps_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_load && bad_req) |=> $stable(pend_ratio));
endmodule

bind swallow_divider swd_checker #(
    .M_W       (M_W),
    .A_W       (A_W),
    .MIN_RATIO (MIN_RATIO)
) u_swd_checker (
    .clk        (clk_in),
    .rst_n      (rst_n),
    .fb_pulse   (fb_pulse),
    .fpd_half   (fpd_half),
    .mod_sel    (mod_sel),
    .ratio_load (ratio_load),
    .ratio_in   (ratio_in),
    .act_ratio  (act_ratio),
    .pend_ratio (pend_ratio)
);

// File: tb/swallow_divider_test.sv
module swallow_divider_test;
    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b0;
    logic [14:0] ratio_in = 15'd0;
    logic        ratio_load = 1'b0;
    logic        fb_pulse, fpd_half, mod_sel;

    always #4 clk_in = ~clk_in;   // 125 MHz

    swallow_divider uut (
        .clk_in     (clk_in),
        .rst_n      (rst_n),
        .ratio_in   (ratio_in),
        .ratio_load (ratio_load),
        .fb_pulse   (fb_pulse),
        .fpd_half   (fpd_half),
        .mod_sel    (mod_sel)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R2";

    // bench reference model of the requirements
    int ref_cnt  = 0;
    int ref_n    = 100;
    int ref_pend = 0;
    bit ref_pvld = 0;
    bit exp_pulse = 0;
    bit exp_half  = 0;
    int pulses_seen = 0;

    function automatic bit req_ok(input logic [14:0] r);
        return (int'(r) >= 64) && (int'(r[14:3]) >= int'(r[2:0]));
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input bit ld, input logic [14:0] r);
        bit take;
        ratio_in   = r;
        ratio_load = ld;
        @(posedge clk_in);
        take = ld && req_ok(r);
        ref_cnt++;
        if (ref_cnt == ref_n) begin
            ref_n     = take ? int'(r) : (ref_pvld ? ref_pend : ref_n);
            ref_pvld  = 0;
            ref_cnt   = 0;
            exp_pulse = 1;
            exp_half  = ~exp_half;
        end else begin
            exp_pulse = 0;
            if (take) begin
                ref_pend = int'(r);
                ref_pvld = 1;
            end
        end
        @(negedge clk_in);
        ratio_load = 1'b0;
        if (exp_pulse) pulses_seen++;
        check(tag,  int'(fb_pulse), int'(exp_pulse), "fb_pulse");
        check("R3", int'(mod_sel), int'(ref_cnt < 9 * (ref_n % 8)), "mod_sel");
        check("R6", int'(fpd_half), int'(exp_half), "fpd_half");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 15'd0);
    endtask

    task automatic wait_pulses(input int k);
        int target;
        target = pulses_seen + k;
        while (pulses_seen < target) tick(0, 15'd0);
    endtask

    task automatic wait_last_cycle();
        while (ref_cnt != ref_n - 1) tick(0, 15'd0);
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk_in);
        // R1: reset state
        check("R1", int'(fb_pulse), 0, "fb_pulse in reset");
        check("R1", int'(fpd_half), 0, "fpd_half in reset");
        check("R1", int'(mod_sel), 1, "mod_sel in reset (default A=4)");
        rst_n = 1'b1;
        tag = "R1";
        wait_pulses(1);   // first pulse after the 100th edge
        tag = "R2";
        wait_pulses(2);

        // R2 / R3 corner ratios: minimum, A=0, A=7
        tick(1, 15'd64);   wait_pulses(3);
        tick(1, 15'd160);  wait_pulses(3);
        tick(1, 15'd71);   wait_pulses(3);

        // R4: strobe on the last cycle governs the next period
        tag = "R4";
        wait_last_cycle();
        tick(1, 15'd90);
        wait_pulses(2);
        // R4: two strobes in one period, last one wins
        tick(1, 15'd200);
        tick(1, 15'd300);
        wait_pulses(3);

        // R5: invalid requests ignored, pending valid ratio kept
        tag = "R5";
        tick(1, 15'd63);   wait_pulses(2);
        tick(1, 15'd7);    wait_pulses(2);
        tick(1, 15'd250);
        tick(1, 15'd10);
        wait_pulses(3);

        // R7: largest ratio
        tag = "R7";
        tick(1, 15'd32767);
        wait_pulses(3);

        // constrained random retunes
        tag = "R4";
        for (int i = 0; i < 60; i++) begin
            logic [14:0] r;
            if (($urandom % 10) == 0) r = 15'($urandom % 64);
            else                      r = 15'(64 + ($urandom % 640));
            idle(int'($urandom % 500));
            tick(1, r);
        end
        wait_pulses(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule